// File: doc/BRIEF.md
# Endpoint Packet FIFO with Automatic Error Recovery

This block wraps the byte FIFO of a single endpoint so that whole packets can be taken back when the bus reports a problem. A writer fills it one byte at a time and closes each packet with an end marker, which carries an error flag for received packets (CRC or bit-stuffing failure). A reader drains it one byte at a time. For transmitted packets, the reader's side is closed by a host result: acknowledged or timed out.

Each side keeps two pointers. The write side has a working write pointer and a committed end-of-packet pointer. The read side has a working read pointer and a start-of-packet pointer. Because of these checkpoints, an erroneous received packet can be dropped, and an unacknowledged transmitted packet can be played out again. Two inputs control this. `iso_mode_i` picks isochronous or non-isochronous handling, and `auto_en_i` turns automatic recovery on. With recovery off, errors are only flagged. A DMA-ready output is raised only when a received packet commits cleanly.

Top module: `ep_fifo_recover`

## Requirements
- R1: After reset: empty_o=1, full_o=0, err_o=0, dma_rdy_o=0.
- R2: Bytes are read out in the order they were written. Bytes written after the last end marker are invisible to the reader: empty_o stays 1 until the marker is taken.
- R3: An end marker with wr_err_i=0 commits the packet. dma_rdy_o is 1 from the clock edge that takes the marker.
- R4: Non-isochronous, recovery on: an end marker with wr_err_i=1 drops every byte of that packet. The next packet is written into the freed space, and the reader gets the earlier committed data followed by the new packet.
- R5: Isochronous, recovery on: an erroneous packet is dropped, empty_o stays 1 and dma_rdy_o is not raised. The next clean packet reads out normally.
- R6: Recovery off: an erroneous received packet is kept and becomes readable. err_o is set and dma_rdy_o is not raised by it.
- R7: Non-isochronous, recovery on: tx_tmo_i returns the read pointer to the packet start, so the same bytes are read again.
- R8: tx_ack_i releases the bytes read since the packet start. full_o clears once space is free.
- R9: Isochronous: tx_tmo_i releases the packet like an ACK, with no replay (empty_o=1 after a fully read packet).
- R10: Non-isochronous, recovery off: tx_tmo_i leaves the read pointer where it is and does not release the bytes, so full_o stays 1.
- R11: err_o is set by any erroneous end marker or any timeout, whatever the mode and enable. It stays set until err_clr_i=1; a set in the same cycle as a clear wins.
- R12: full_o=1 when 64 bytes lie between the start-of-packet read pointer and the write pointer. A write while full_o=1 is ignored.
- R13: dma_rdy_o clears on the clock edge after the reader drains the FIFO to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iso_mode_i | input | 1 | 1 = isochronous handling, 0 = bulk/interrupt/control |
| auto_en_i | input | 1 | Enables automatic recovery |
| wr_en_i | input | 1 | Write one byte |
| wr_data_i | input | 8 | Write byte |
| wr_eop_i | input | 1 | End of packet on the write side (a byte written in the same cycle belongs to the packet) |
| wr_err_i | input | 1 | Packet error flag, valid with wr_eop_i |
| rd_en_i | input | 1 | Consume one byte |
| rd_data_o | output | 8 | Byte at the read pointer |
| tx_ack_i | input | 1 | Host acknowledged the transmitted packet |
| tx_tmo_i | input | 1 | No acknowledge (timeout); ignored if tx_ack_i is also 1 |
| err_clr_i | input | 1 | Clears err_o |
| full_o | output | 1 | No room for another byte |
| empty_o | output | 1 | No committed byte left to read |
| dma_rdy_o | output | 1 | A clean received packet is waiting |
| err_o | output | 1 | Sticky error status |

## Verification
Every pointer, err_o and the set of dma_rdy_o change on the clock edge that takes the stimulus. empty_o, full_o and rd_data_o are decoded from the pointers without a register, so they show the new value after that same edge. The only two-edge result is the clear of dma_rdy_o: empty_o rises on the edge of the last read, and dma_rdy_o falls on the following edge. The bench drives inputs on the falling edge and samples on the next falling edge. It waits one extra cycle only where the dma_rdy_o clear calls for it.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
  typedef enum logic {XFER_BULK = 1'b0, XFER_ISO = 1'b1} xfer_mode_e;
  typedef enum logic [1:0] {TXR_NONE, TXR_ACK, TXR_TMO} tx_res_e;
endpackage

// File: rtl/efr_mem.sv
module efr_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/efr_wr_ctl.sv
module efr_wr_ctl #(
  parameter int PW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          auto_en_i,
  input  logic          wr_en_i,
  input  logic          full_i,
  input  logic          eop_i,
  input  logic          err_i,
  output logic          wr_fire_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] wr_cmt_o,
  output logic          clean_cmt_o,
  output logic          err_evt_o
);
  logic [PW-1:0] ptr_q, cmt_q, ptr_nxt;

  assign wr_fire_o   = wr_en_i && !full_i;
  assign ptr_nxt     = ptr_q + PW'(wr_fire_o);
  assign clean_cmt_o = eop_i && !err_i;
  assign err_evt_o   = eop_i && err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cmt_q <= '0;
    end else if (eop_i) begin
      if (err_i && auto_en_i) begin
        ptr_q <= cmt_q;            // drop the packet
      end else begin
        ptr_q <= ptr_nxt;
        cmt_q <= ptr_nxt;
      end
    end else begin
      ptr_q <= ptr_nxt;
    end
  end

  assign wr_ptr_o = ptr_q;
  assign wr_cmt_o = cmt_q;
endmodule

// File: rtl/efr_rd_ctl.sv
module efr_rd_ctl
  import ep_fifo_pkg::*;
#(
  parameter int PW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          iso_i,
  input  logic          auto_en_i,
  input  logic          rd_en_i,
  input  logic          empty_i,
  input  logic          ack_i,
  input  logic          tmo_i,
  output logic [PW-1:0] rd_ptr_o,
  output logic [PW-1:0] rd_sop_o
);
  logic [PW-1:0] ptr_q, sop_q, ptr_nxt;
  xfer_mode_e    mode;
  tx_res_e       res;

  assign mode    = xfer_mode_e'(iso_i);
  assign ptr_nxt = ptr_q + PW'(rd_en_i && !empty_i);

  always_comb begin
    if (ack_i)      res = TXR_ACK;
    else if (tmo_i) res = TXR_TMO;
    else            res = TXR_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      sop_q <= '0;
    end else begin
      case (res)
        TXR_ACK: begin
          ptr_q <= ptr_nxt;
          sop_q <= ptr_nxt;
        end
        TXR_TMO: begin
          if (mode == XFER_ISO) begin
            ptr_q <= ptr_nxt;
            sop_q <= ptr_nxt;
          end else if (auto_en_i) begin
            ptr_q <= sop_q;        // replay from packet start
          end else begin
            ptr_q <= ptr_nxt;
          end
        end
        default: ptr_q <= ptr_nxt;
      endcase
    end
  end

  assign rd_ptr_o = ptr_q;
  assign rd_sop_o = sop_q;
endmodule

// File: rtl/ep_fifo_recover.sv
module ep_fifo_recover #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          iso_mode_i,
  input  logic          auto_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_eop_i,
  input  logic          wr_err_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          tx_ack_i,
  input  logic          tx_tmo_i,
  input  logic          err_clr_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          dma_rdy_o,
  output logic          err_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr, wr_cmt, rd_ptr, rd_sop;
  logic          wr_fire, clean_cmt, err_evt, tmo_evt;
  logic          err_q, rdy_q;

  assign full_o  = (wr_ptr[AW] != rd_sop[AW]) && (wr_ptr[AW-1:0] == rd_sop[AW-1:0]);
  assign empty_o = (rd_ptr == wr_cmt);
  assign tmo_evt = tx_tmo_i && !tx_ack_i;

  efr_wr_ctl #(.PW(PW)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .auto_en_i  (auto_en_i),
    .wr_en_i    (wr_en_i),
    .full_i     (full_o),
    .eop_i      (wr_eop_i),
    .err_i      (wr_err_i),
    .wr_fire_o  (wr_fire),
    .wr_ptr_o   (wr_ptr),
    .wr_cmt_o   (wr_cmt),
    .clean_cmt_o(clean_cmt),
    .err_evt_o  (err_evt)
  );

  efr_rd_ctl #(.PW(PW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .iso_i    (iso_mode_i),
    .auto_en_i(auto_en_i),
    .rd_en_i  (rd_en_i),
    .empty_i  (empty_o),
    .ack_i    (tx_ack_i),
    .tmo_i    (tx_tmo_i),
    .rd_ptr_o (rd_ptr),
    .rd_sop_o (rd_sop)
  );

  efr_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_fire),
    .waddr_i(wr_ptr[AW-1:0]),
    .wdata_i(wr_data_i),
    .raddr_i(rd_ptr[AW-1:0]),
    .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      if (err_evt || tmo_evt) err_q <= 1'b1;
      else if (err_clr_i)     err_q <= 1'b0;
      if (clean_cmt)          rdy_q <= 1'b1;
      else if (empty_o)       rdy_q <= 1'b0;
    end
  end

  assign err_o     = err_q;
  assign dma_rdy_o = rdy_q;
endmodule

// File: rtl/efr_checker.sv
module efr_checker #(
  parameter int PW    = 7,
  parameter int DEPTH = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          iso_mode_i,
  input logic          auto_en_i,
  input logic          wr_eop_i,
  input logic          wr_err_i,
  input logic          tx_ack_i,
  input logic          tx_tmo_i,
  input logic          err_o,
  input logic          dma_rdy_o,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] wr_cmt,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] rd_sop
);
  logic [PW-1:0] fill;
  assign fill = wr_ptr - rd_sop;

  a_r4_flush_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_eop_i && wr_err_i && auto_en_i) |=> (wr_ptr == $past(wr_cmt)));

  a_r5_no_dma_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_eop_i && wr_err_i) |=> !$rose(dma_rdy_o));

  a_r7_tx_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iso_mode_i && auto_en_i && tx_tmo_i && !tx_ack_i) |=> (rd_ptr == $past(rd_sop)));

  a_r9_iso_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_mode_i && tx_tmo_i && !tx_ack_i) |=> (rd_sop == rd_ptr));

  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_eop_i && wr_err_i) || (tx_tmo_i && !tx_ack_i)) |=> err_o);

  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= PW'(DEPTH));
endmodule

bind ep_fifo_recover efr_checker #(.PW($clog2(DEPTH) + 1), .DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .iso_mode_i(iso_mode_i),
  .auto_en_i (auto_en_i),
  .wr_eop_i  (wr_eop_i),
  .wr_err_i  (wr_err_i),
  .tx_ack_i  (tx_ack_i),
  .tx_tmo_i  (tx_tmo_i),
  .err_o     (err_o),
  .dma_rdy_o (dma_rdy_o),
  .wr_ptr    (wr_ptr),
  .wr_cmt    (wr_cmt),
  .rd_ptr    (rd_ptr),
  .rd_sop    (rd_sop)
);

// File: tb/ep_fifo_recover_bench.sv
`timescale 1ns/1ps
module ep_fifo_recover_bench;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic iso_mode_i = 0, auto_en_i = 0, wr_en_i = 0, wr_eop_i = 0, wr_err_i = 0;
  logic rd_en_i = 0, tx_ack_i = 0, tx_tmo_i = 0, err_clr_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic full_o, empty_o, dma_rdy_o, err_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ep_fifo_recover u_ep_fifo_recover (
    .clk_i(clk), .rst_ni(rst_ni), .iso_mode_i(iso_mode_i), .auto_en_i(auto_en_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .wr_eop_i(wr_eop_i), .wr_err_i(wr_err_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .tx_ack_i(tx_ack_i), .tx_tmo_i(tx_tmo_i),
    .err_clr_i(err_clr_i), .full_o(full_o), .empty_o(empty_o), .dma_rdy_o(dma_rdy_o),
    .err_o(err_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit iso, bit auto_en);
    rst_ni = 0; iso_mode_i = iso; auto_en_i = auto_en;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic wr_bytes(int base, int n);
    for (int i = 0; i < n; i++) begin
      wr_en_i = 1; wr_data_i = 8'(base + i);
      @(negedge clk);
    end
    wr_en_i = 0;
  endtask

  task automatic eop(bit err);
    wr_eop_i = 1; wr_err_i = err;
    @(negedge clk);
    wr_eop_i = 0; wr_err_i = 0;
  endtask

  task automatic rd_check(int base, int n, string req);
    for (int i = 0; i < n; i++) begin
      chk({req, " not empty"}, int'(empty_o), 0);
      chk({req, " data"}, int'(rd_data_o), (base + i) & 8'hff);
      rd_en_i = 1;
      @(negedge clk);
    end
    rd_en_i = 0;
  endtask

  task automatic tx_res(bit ack, bit tmo);
    tx_ack_i = ack; tx_tmo_i = tmo;
    @(negedge clk);
    tx_ack_i = 0; tx_tmo_i = 0;
  endtask

  task automatic t_reset;
    do_reset(0, 1);
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 full", int'(full_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 dma_rdy", int'(dma_rdy_o), 0);
  endtask

  task automatic t_clean_rx;
    do_reset(0, 1);
    wr_bytes(8'h31, 3);
    chk("R2 uncommitted hidden", int'(empty_o), 1);
    eop(0);
    chk("R3 dma_rdy after eop", int'(dma_rdy_o), 1);
    rd_check(8'h31, 3, "R2");
    chk("R13 drained empty", int'(empty_o), 1);
    chk("R13 rdy one more edge", int'(dma_rdy_o), 1);
    @(negedge clk);
    chk("R13 rdy cleared", int'(dma_rdy_o), 0);
  endtask

  task automatic t_noniso_flush;
    do_reset(0, 1);
    wr_bytes(8'h10, 3); eop(0);
    wr_bytes(8'h40, 4); eop(1);
    chk("R11 err set", int'(err_o), 1);
    wr_bytes(8'h70, 2); eop(0);
    rd_check(8'h10, 3, "R4 first pkt");
    rd_check(8'h70, 2, "R4 re-received pkt");
    chk("R4 nothing left", int'(empty_o), 1);
  endtask

  task automatic t_iso_discard;
    do_reset(1, 1);
    wr_bytes(8'h50, 5); eop(1);
    chk("R5 empty", int'(empty_o), 1);
    chk("R5 no dma_rdy", int'(dma_rdy_o), 0);
    chk("R11 err iso", int'(err_o), 1);
    wr_bytes(8'h90, 2); eop(0);
    chk("R5 next pkt ready", int'(dma_rdy_o), 1);
    rd_check(8'h90, 2, "R5");
  endtask

  task automatic t_auto_off_rx;
    do_reset(0, 0);
    wr_bytes(8'hA0, 3); eop(1);
    chk("R6 kept", int'(empty_o), 0);
    chk("R6 no dma_rdy", int'(dma_rdy_o), 0);
    chk("R6 err", int'(err_o), 1);
    rd_check(8'hA0, 3, "R6");
  endtask

  task automatic t_tx_replay;
    do_reset(0, 1);
    wr_bytes(8'h20, 4); eop(0);
    rd_check(8'h20, 4, "R7 first send");
    chk("R7 empty before tmo", int'(empty_o), 1);
    tx_res(0, 1);
    chk("R11 err on tmo", int'(err_o), 1);
    rd_check(8'h20, 4, "R7 replay");
    tx_res(1, 0);
    chk("R8 empty after ack", int'(empty_o), 1);
  endtask

  task automatic t_iso_tx;
    do_reset(1, 1);
    wr_bytes(8'hC0, 4); eop(0);
    rd_check(8'hC0, 4, "R9 send");
    tx_res(0, 1);
    chk("R9 no replay", int'(empty_o), 1);
    wr_bytes(8'h00, DEPTH); eop(0);
    chk("R9 space released", int'(full_o), 1);
    rd_check(8'h00, 1, "R9 new data");
  endtask

  task automatic t_full_hold;
    do_reset(0, 0);
    wr_bytes(8'h00, DEPTH); eop(0);
    chk("R12 full", int'(full_o), 1);
    rd_check(8'h00, DEPTH, "R12");
    chk("R8 still full before ack", int'(full_o), 1);
    tx_res(0, 1);
    chk("R10 no rewind", int'(empty_o), 1);
    chk("R10 not released", int'(full_o), 1);
    wr_bytes(8'hEE, 1);
    tx_res(1, 0);
    chk("R8 full cleared", int'(full_o), 0);
    eop(0);
    chk("R12 write when full ignored", int'(empty_o), 1);
  endtask

  task automatic t_err_clear;
    do_reset(0, 1);
    wr_bytes(8'h01, 1); eop(1);
    chk("R11 set", int'(err_o), 1);
    err_clr_i = 1; @(negedge clk); err_clr_i = 0;
    chk("R11 cleared", int'(err_o), 0);
    wr_eop_i = 1; wr_err_i = 1; err_clr_i = 1;
    @(negedge clk);
    wr_eop_i = 0; wr_err_i = 0; err_clr_i = 0;
    chk("R11 set wins over clear", int'(err_o), 1);
  endtask

  initial begin
    t_reset();
    t_clean_rx();
    t_noniso_flush();
    t_iso_discard();
    t_auto_off_rx();
    t_tx_replay();
    t_iso_tx();
    t_full_hold();
    t_err_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule